// File: doc/BRIEF.md
# March-Test Memory Self-Test Engine with In-Place Repair

This block is an on-chip self-test engine for a small single-port RAM. A start pulse launches a fixed sequence of six march passes. Each pass visits every word once, in rising or falling address order, and applies its own read and/or write. The written word is either all zeros or all ones. The RAM is read asynchronously and written on the clock edge. This lets the engine read a word, compare it and write the same word in one cycle, so every pass costs exactly one cycle per address.

Each read is compared with the word the march expects at that point. On a mismatch the engine does four things. It raises an error pulse, holds back that cycle's write, and latches the failing address and the correct word. It then moves into repair: one cycle rewrites the latched word at the latched address, after which a repaired flag stays up until the continue input is seen. The march then resumes at the same address and repeats the operation that failed. A small repair budget limits how many repairs a run may use. A mismatch found after the budget is spent is reported as not repairable, and the run ends at once with a fail result.

Top module: `mbist_march`

## Requirements
- R1: After reset the engine is idle. `busy_o`, `done_o`, `mem_we_o`, `mem_re_o`, `repaired_o` and `pass_o` are all 0.
- R2: A run is six passes in this order: rising w0; rising r0,w1; rising r1,w0; falling r0,w1; falling r1,w0; rising r0. "Rising" means addresses 0 up to DEPTH-1 and "falling" means DEPTH-1 down to 0. Every address finishes its pass before the next address starts, and every pass finishes before the next pass starts.
- R3: When no faults are present, `done_o` is high in the cycle that follows 6*DEPTH consecutive busy cycles after the start cycle. That is one cycle per address per pass, with a read and a write to the same word in a single cycle.
- R4: A read whose data differs from the expected word raises `err_o` in that cycle. From the next cycle, `err_addr_o` holds the failing address and `err_data_o` holds the expected word.
- R5: No march write occurs in a mismatch cycle. When the budget allows a repair, the next cycle writes `err_data_o` to `err_addr_o`.
- R6: `repaired_o` rises in the cycle after the repair write and stays high until `cont_i` is sampled high. The march then repeats the failed operation at the same address, so one repair adds exactly 6 cycles to the run when `cont_i` arrives on the fourth repaired cycle.
- R7: A run allows at most REP_MAX repairs. From the cycle after a mismatch, `repairable_o` is 1 if a repair was still available and 0 if not. A mismatch with no repair left ends the run with `pass_o`=0.
- R8: `done_o` is a single-cycle pulse. `pass_o` is 1 only if the run met no unrepairable fault, and it keeps its value until the next start.
- R9: `start_i` has no effect while `busy_o` is high.
- R10: The data used for writes and expected reads is a whole word of zeros (0x00 for DW=8) or a whole word of ones (0xFF for DW=8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the engine is idle |
| cont_i | input | 1 | Lets the march resume after a repair |
| mem_addr_o | output | $clog2(DEPTH) | RAM address |
| mem_we_o | output | 1 | RAM write enable, write taken at the clock edge |
| mem_wdata_o | output | DW | RAM write data |
| mem_re_o | output | 1 | Marks a cycle whose read data is compared |
| mem_rdata_i | input | DW | Asynchronous RAM read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run result, valid from `done_o` until the next start |
| err_o | output | 1 | Mismatch in the current cycle |
| err_addr_o | output | $clog2(DEPTH) | Latched failing address |
| err_data_o | output | DW | Latched expected word |
| repaired_o | output | 1 | Repair written, waiting for continue |
| repairable_o | output | 1 | Last mismatch fit within the repair budget |

## Verification
The compare of a read and the march write to the same word happen in the same cycle. A mismatch must therefore cancel that write and hand the correct word to the repair cycle. The bench provokes this with single-cell faults in the behavioural RAM: stuck-at-1, stuck-at-0, and a one-shot failed rise from 0 to 1. These sit at random and at edge addresses and bit positions, so the mismatch falls in a read-then-write pass. The bench then checks the reported address and word and the repaired flag. It checks the raw RAM content right after the repair write, the extra cycles the run takes, and the repair counts and final result when the budget runs out.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUN,
      ST_FIX,
      ST_HOLD,
      ST_FIN
   } mb_state_e;

   typedef struct packed {
      logic down;
      logic rd;
      logic rd_val;
      logic wr;
      logic wr_val;
   } pass_t;

   localparam int unsigned NUM_PASSES = 6;

   function automatic pass_t pass_desc(input logic [2:0] idx);
      pass_t p;
      p = '0;
      case (idx)
         3'd0: begin p.wr = 1'b1; p.wr_val = 1'b0; end
         3'd1: begin p.rd = 1'b1; p.rd_val = 1'b0; p.wr = 1'b1; p.wr_val = 1'b1; end
         3'd2: begin p.rd = 1'b1; p.rd_val = 1'b1; p.wr = 1'b1; p.wr_val = 1'b0; end
         3'd3: begin p.down = 1'b1; p.rd = 1'b1; p.rd_val = 1'b0; p.wr = 1'b1; p.wr_val = 1'b1; end
         3'd4: begin p.down = 1'b1; p.rd = 1'b1; p.rd_val = 1'b1; p.wr = 1'b1; p.wr_val = 1'b0; end
         3'd5: begin p.rd = 1'b1; p.rd_val = 1'b0; end
         default: p = '0;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          adv_i,
   input  logic          down_i,
   output logic [AW-1:0] addr_o,
   output logic          last_o
);

   localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);
   localparam bit            POW2     = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbist_addr_seq: DEPTH must be at least 2");
   end

   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (adv_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == TOP_ADDR);

   if (POW2) begin : g_pow2
      assign addr_o = down_i ? ~cnt_q : cnt_q;
   end else begin : g_any
      assign addr_o = down_i ? (TOP_ADDR - cnt_q) : cnt_q;
   end

   // R2: address never leaves the array
   p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, addr_o} < (AW + 1)'(DEPTH));
   // R2: the sequencer never steps past the final address of a pass
   p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> !adv_i);

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          exp_bit_i,
   input  logic [DW-1:0] rdata_i,
   input  logic [AW-1:0] addr_i,
   output logic          miss_o,
   output logic [AW-1:0] cap_addr_o,
   output logic [DW-1:0] cap_data_o
);

   logic [DW-1:0] exp_word;

   assign exp_word = {DW{exp_bit_i}};
   assign miss_o   = en_i && (rdata_i != exp_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr_o <= '0;
         cap_data_o <= '0;
      end else if (miss_o) begin
         cap_addr_o <= addr_i;
         cap_data_o <= exp_word;
      end
   end

   // R10: the latched correct word is always a uniform background
   p_uniform_bg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |=> (cap_data_o == '0) || (cap_data_o == '1));

endmodule

// File: rtl/mbist_march.sv
module mbist_march #(
   parameter int DEPTH   = 16,
   parameter int DW      = 8,
   parameter int REP_MAX = 4,
   parameter int AW      = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          cont_i,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_we_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          mem_re_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          err_o,
   output logic [AW-1:0] err_addr_o,
   output logic [DW-1:0] err_data_o,
   output logic          repaired_o,
   output logic          repairable_o
);
   import mbist_pkg::*;

   localparam int         CW        = $clog2(REP_MAX + 1);
   localparam logic [2:0] LAST_PASS = 3'(NUM_PASSES - 1);

   if (DW < 1) begin : g_bad_dw
      $error("mbist_march: DW must be at least 1");
   end
   if (REP_MAX < 1) begin : g_bad_rep
      $error("mbist_march: REP_MAX must be at least 1");
   end

   mb_state_e     state_q;
   logic [2:0]    pass_q;
   logic [CW-1:0] rep_cnt_q;
   logic          pass_ok_q;
   logic          fixable_q;

   pass_t         cur;
   logic          run, miss, last, clr, adv, budget_ok;
   logic [AW-1:0] seq_addr, cap_addr;
   logic [DW-1:0] cap_data;

   assign cur       = pass_desc(pass_q);
   assign run       = (state_q == ST_RUN);
   assign budget_ok = rep_cnt_q < CW'(REP_MAX);
   assign clr       = ((state_q == ST_IDLE) && start_i) ||
                      (run && !miss && last && (pass_q != LAST_PASS));
   assign adv       = run && !miss && !last;

   mbist_addr_seq #(.DEPTH(DEPTH), .AW(AW)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .adv_i  (adv),
      .down_i (cur.down),
      .addr_o (seq_addr),
      .last_o (last)
   );

   mbist_cmp #(.DW(DW), .AW(AW)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (run && cur.rd),
      .exp_bit_i  (cur.rd_val),
      .rdata_i    (mem_rdata_i),
      .addr_i     (seq_addr),
      .miss_o     (miss),
      .cap_addr_o (cap_addr),
      .cap_data_o (cap_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pass_q    <= '0;
         rep_cnt_q <= '0;
         pass_ok_q <= 1'b0;
         fixable_q <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q   <= ST_RUN;
               pass_q    <= '0;
               rep_cnt_q <= '0;
               pass_ok_q <= 1'b1;
               fixable_q <= 1'b1;
            end
            ST_RUN: begin
               if (miss) begin
                  fixable_q <= budget_ok;
                  if (budget_ok) begin
                     state_q <= ST_FIX;
                  end else begin
                     pass_ok_q <= 1'b0;
                     state_q   <= ST_FIN;
                  end
               end else if (last) begin
                  if (pass_q == LAST_PASS) state_q <= ST_FIN;
                  else                     pass_q  <= pass_q + 3'd1;
               end
            end
            ST_FIX: begin
               rep_cnt_q <= rep_cnt_q + 1'b1;
               state_q   <= ST_HOLD;
            end
            ST_HOLD: if (cont_i) state_q <= ST_RUN;
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_addr_o   = (state_q == ST_FIX) ? cap_addr : seq_addr;
   assign mem_we_o     = (run && cur.wr && !miss) || (state_q == ST_FIX);
   assign mem_wdata_o  = (state_q == ST_FIX) ? cap_data : {DW{cur.wr_val}};
   assign mem_re_o     = run && cur.rd;
   assign busy_o       = run || (state_q == ST_FIX) || (state_q == ST_HOLD);
   assign done_o       = (state_q == ST_FIN);
   assign pass_o       = pass_ok_q;
   assign err_o        = miss;
   assign err_addr_o   = cap_addr;
   assign err_data_o   = cap_data;
   assign repaired_o   = (state_q == ST_HOLD);
   assign repairable_o = fixable_q;

   // R8: end-of-run indication lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R5: a mismatching read never lets the march write through
   p_no_we_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !mem_we_o);
   // R5: the repaired flag follows a write to the latched address
   p_fix_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(repaired_o) |-> $past(mem_we_o) && ($past(mem_addr_o) == err_addr_o));
   // R6: the repaired flag waits for continue
   p_hold_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      repaired_o && !cont_i |=> repaired_o);
   // R7: the repair budget is never exceeded
   p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rep_cnt_q <= CW'(REP_MAX));
   // R9: a run keeps going whatever start does
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o && start_i |=> busy_o || done_o);

endmodule

// File: tb/sim_mbist_march.sv
`timescale 1ns/1ps
module sim_mbist_march;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int AW    = 4;
   localparam int RMAX  = 4;
   localparam int RUNLEN = 6 * DEPTH + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, cont_i = 1'b0;
   logic [AW-1:0] mem_addr_o, err_addr_o;
   logic [DW-1:0] mem_wdata_o, mem_rdata_i, err_data_o;
   logic mem_we_o, mem_re_o, busy_o, done_o, pass_o, err_o, repaired_o, repairable_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mbist_march #(.DEPTH(DEPTH), .DW(DW), .REP_MAX(RMAX)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
      .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
      .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
      .done_o(done_o), .pass_o(pass_o), .err_o(err_o), .err_addr_o(err_addr_o),
      .err_data_o(err_data_o), .repaired_o(repaired_o), .repairable_o(repairable_o));

   // behavioural RAM with injectable single-cell faults
   logic [DW-1:0] ram [DEPTH];
   logic mem_clr = 1'b0;
   logic sa_en = 1'b0, sa_val = 1'b0, tf_en = 1'b0, tf_used;
   logic [AW-1:0] sa_addr = '0, tf_addr = '0;
   int sa_bit = 0, tf_bit = 0;

   always_comb begin
      mem_rdata_i = ram[mem_addr_o];
      if (sa_en && mem_addr_o == sa_addr) mem_rdata_i[sa_bit] = sa_val;
   end

   always @(posedge clk) begin
      if (mem_clr) begin
         for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
         tf_used <= 1'b0;
      end else if (mem_we_o) begin
         logic [DW-1:0] nv;
         nv = mem_wdata_o;
         if (tf_en && !tf_used && mem_addr_o == tf_addr &&
             !ram[mem_addr_o][tf_bit] && nv[tf_bit]) begin
            nv[tf_bit] = 1'b0;
            tf_used <= 1'b1;
         end
         ram[mem_addr_o] <= nv;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_addr(input int i);
      int p = (i - 1) / DEPTH;
      int k = (i - 1) % DEPTH;
      return (p == 3 || p == 4) ? DEPTH - 1 - k : k;
   endfunction

   int cyc, n_err, n_rep, f_addr, f_data, f_fix, l_fix, tr_bad, ram_bad, hold_bad, pdone;
   bit got_done;

   task automatic run_case(input bit trace_on);
      bit pend = 1'b0, first_seen = 1'b0, prev_rep = 1'b0, prev_cont = 1'b0;
      int hold_cnt = 0;
      cyc = 0; n_err = 0; n_rep = 0; f_addr = -1; f_data = -1; f_fix = -1; l_fix = -1;
      tr_bad = 0; ram_bad = 0; hold_bad = 0; got_done = 1'b0;
      mem_clr = 1'b1;
      @(negedge clk);
      mem_clr = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (cyc < 5000) begin
         cyc++;
         start_i = 1'b0;
         cont_i = 1'b0;
         if (pend) begin
            if (!first_seen) begin
               f_addr = int'(err_addr_o); f_data = int'(err_data_o); f_fix = int'(repairable_o);
               first_seen = 1'b1;
            end
            l_fix = int'(repairable_o);
            pend = 1'b0;
         end
         if (err_o) begin n_err++; pend = 1'b1; end
         if (trace_on && cyc <= 6 * DEPTH) begin
            int p = (cyc - 1) / DEPTH;
            bit we_e = (p != 5);
            bit re_e = (p != 0);
            logic [DW-1:0] wd_e = (p == 1 || p == 3) ? '1 : '0;
            if (int'(mem_addr_o) != exp_addr(cyc) || mem_we_o != we_e || mem_re_o != re_e ||
                (we_e && mem_wdata_o != wd_e) || !busy_o) tr_bad++;
         end
         if (trace_on && cyc == 40) start_i = 1'b1;
         if (prev_rep && !repaired_o && !prev_cont) hold_bad++;
         if (repaired_o) begin
            hold_cnt++;
            if (hold_cnt == 1) begin
               n_rep++;
               if (ram[err_addr_o] != err_data_o) ram_bad++;
            end
            if (hold_cnt == 4) cont_i = 1'b1;
         end else hold_cnt = 0;
         prev_rep = repaired_o;
         prev_cont = cont_i;
         if (done_o) begin got_done = 1'b1; break; end
         @(negedge clk);
      end
      start_i = 1'b0;
      cont_i = 1'b0;
      pdone = int'(pass_o);
      @(negedge clk);
      chk(!done_o, "R8", "done pulse length", int'(done_o), 0);
      chk(pass_o == pdone[0], "R8", "pass held after done", int'(pass_o), pdone);
   endtask

   // kind: 0 one-shot failed rise, 1 stuck-at-1, 2 stuck-at-0
   task automatic fault_case(input int kind, input int a, input int b);
      bit tf = (kind == 0);
      int exp_d = (kind == 1) ? 0 : 255;
      sa_en = !tf; sa_val = (kind == 1); sa_addr = AW'(a); sa_bit = b;
      tf_en = tf; tf_addr = AW'(a); tf_bit = b;
      run_case(1'b0);
      sa_en = 1'b0; tf_en = 1'b0;
      chk(got_done, "R7", "run ended", int'(got_done), 1);
      chk(f_addr == a, "R4", "failing address", f_addr, a);
      chk(f_data == exp_d, "R10", "expected word", f_data, exp_d);
      chk(ram_bad == 0, "R5", "repair write restores word", ram_bad, 0);
      chk(hold_bad == 0, "R6", "repaired held until continue", hold_bad, 0);
      chk(f_fix == 1, "R7", "first fault repairable", f_fix, 1);
      if (tf) begin
         chk(n_err == 1 && n_rep == 1, "R5", "single repair count", n_err * 10 + n_rep, 11);
         chk(cyc == RUNLEN + 6, "R6", "resume at same address", cyc, RUNLEN + 6);
         chk(pdone == 1, "R8", "pass after repair", pdone, 1);
      end else begin
         chk(n_err == RMAX + 1 && n_rep == RMAX, "R7", "budget spent",
             n_err * 10 + n_rep, (RMAX + 1) * 10 + RMAX);
         chk(l_fix == 0, "R7", "last fault not repairable", l_fix, 0);
         chk(pdone == 0, "R7", "fail result", pdone, 0);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !mem_we_o && !mem_re_o && !repaired_o && !pass_o,
          "R1", "reset outputs idle",
          int'({busy_o, done_o, mem_we_o, mem_re_o, repaired_o, pass_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o, "R1", "idle after reset release", int'(busy_o), 0);

      run_case(1'b1);
      chk(tr_bad == 0, "R2", "march order and data trace", tr_bad, 0);
      chk(cyc == RUNLEN, "R3", "cycles to done", cyc, RUNLEN);
      chk(cyc == RUNLEN, "R9", "start during run ignored", cyc, RUNLEN);
      chk(n_err == 0 && pdone == 1, "R8", "clean run passes", n_err * 10 + pdone, 1);

      fault_case(0, 0, 0);
      fault_case(1, DEPTH - 1, DW - 1);
      fault_case(2, 0, DW - 1);
      for (int it = 0; it < 6; it++)
         fault_case(int'($urandom % 3), int'($urandom % DEPTH), int'($urandom % DW));

      run_case(1'b1);
      chk(tr_bad == 0 && pdone == 1, "R2", "clean run after faults", tr_bad, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule